// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox Pair

This block holds two single-word message registers that pass short control words between two ports running on unrelated clocks. One register carries words from port A to port B. The other carries words from port B to port A. Each register has an active-low full flag in the writer's clock domain. A write drives the flag low. While the flag is low, further writes to that register are dropped. The flag returns high only after the far port has read the word. The read event reaches the writer's domain as a toggle through a short synchronizer chain.

Each port has a direction select, and the two ports use opposite polarities. Each port also has a mailbox select that steers the access either to its mailbox or to the neighbouring FIFO path. The FIFO storage itself lies outside this block. Its output words come in as plain inputs, and the read multiplexer of each port chooses between them and the mailbox word. An output-enable signal per port replaces the pad drivers.

Two resets, one per direction, clear the matching register and its flag. Each reset is asserted asynchronously in both clock domains.

Top module: `mailbox_pair`

## Requirements
- R1: Port A direction: `a_wr_rd` = 1 means write and 0 means read, sampled on the rising edge of `clk_a`. `a_oe` is 1 exactly when `a_wr_rd` is 0.
- R2: Port B direction has the opposite polarity: `b_wr_rd` = 0 means write and 1 means read, sampled on the rising edge of `clk_b`. `b_oe` is 1 exactly when `b_wr_rd` is 1.
- R3: A port A write with `a_mbx_sel` = 1 while `mail1_full_n` = 1 loads `a_wdata` into the A-to-B register and drives `mail1_full_n` to 0 after that `clk_a` edge.
- R4: While `mail1_full_n` is 0, port A mailbox writes are ignored, and a later port B mailbox read returns the first word.
- R5: `mail1_full_n` stays 0 until port B performs a mailbox read (`b_wr_rd` = 1, `b_mbx_sel` = 1). After that read it returns to 1 within SYNC_STAGES+1 rising edges of `clk_a`.
- R6: The B-to-A register mirrors R3 to R5 with the roles swapped. A port B mailbox write drives `mail2_full_n` to 0. Writes are dropped while it is 0. A port A mailbox read (`a_wr_rd` = 0, `a_mbx_sel` = 1) returns it to 1 within SYNC_STAGES+1 `clk_b` edges.
- R7: Read multiplexers: `a_rdata` shows the B-to-A register when `a_mbx_sel` = 1 and `fifo2_q` otherwise. `b_rdata` shows the A-to-B register when `b_mbx_sel` = 1 and `fifo1_q` otherwise.
- R8: `rst1_n` low forces `mail1_full_n` to 1 and the A-to-B register to zero. `rst2_n` low does the same for `mail2_full_n` and the B-to-A register. Neither reset disturbs the other direction.
- R9: A write with the mailbox select at 0 (a FIFO write) changes neither mailbox register nor its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst1_n | input | 1 | Active-low reset of the A-to-B direction |
| rst2_n | input | 1 | Active-low reset of the B-to-A direction |
| a_wr_rd | input | 1 | Port A direction, 1 = write |
| a_mbx_sel | input | 1 | Port A mailbox select |
| a_wdata | input | WIDTH | Port A write data |
| fifo2_q | input | WIDTH | Output word of the B-to-A FIFO |
| a_rdata | output | WIDTH | Port A read data |
| a_oe | output | 1 | Port A data output enable |
| mail1_full_n | output | 1 | A-to-B register full flag, active low, `clk_a` domain |
| b_wr_rd | input | 1 | Port B direction, 0 = write |
| b_mbx_sel | input | 1 | Port B mailbox select |
| b_wdata | input | WIDTH | Port B write data |
| fifo1_q | input | WIDTH | Output word of the A-to-B FIFO |
| b_rdata | output | WIDTH | Port B read data |
| b_oe | output | 1 | Port B data output enable |
| mail2_full_n | output | 1 | B-to-A register full flag, active low, `clk_b` domain |

## Verification
The bench builds the block with WIDTH = 36 and SYNC_STAGES = 2. The 36-bit width allows words that differ in both halves, so a dropped overwrite is told apart from an accepted one. The two-stage chain bounds the flag release to three writer-clock edges, so a five-cycle wait after each far-side read decides R5 and R6 even with clocks of 10 ns and 17 ns that never share an edge.

// File: rtl/mailbox_pair.sv
module mailbox_pair #(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst1_n,
  input  logic             rst2_n,
  input  logic             a_wr_rd,
  input  logic             a_mbx_sel,
  input  logic [WIDTH-1:0] a_wdata,
  input  logic [WIDTH-1:0] fifo2_q,
  output logic [WIDTH-1:0] a_rdata,
  output logic             a_oe,
  output logic             mail1_full_n,
  input  logic             b_wr_rd,
  input  logic             b_mbx_sel,
  input  logic [WIDTH-1:0] b_wdata,
  input  logic [WIDTH-1:0] fifo1_q,
  output logic [WIDTH-1:0] b_rdata,
  output logic             b_oe,
  output logic             mail2_full_n
);

  localparam int SHW = SYNC_STAGES + 1;

  logic a_mbx_wr, a_mbx_rd, b_mbx_wr, b_mbx_rd;
  assign a_mbx_wr = a_wr_rd & a_mbx_sel;
  assign a_mbx_rd = ~a_wr_rd & a_mbx_sel;
  assign b_mbx_wr = ~b_wr_rd & b_mbx_sel;
  assign b_mbx_rd = b_wr_rd & b_mbx_sel;

  // A-to-B direction
  logic [WIDTH-1:0] mail1_q;
  logic             full1, rd1_tog, clr1;
  logic [SHW-1:0]   rd1_sh;

  always_ff @(posedge clk_b or negedge rst1_n)
    if (!rst1_n)       rd1_tog <= 1'b0;
    else if (b_mbx_rd) rd1_tog <= ~rd1_tog;

  always_ff @(posedge clk_a or negedge rst1_n)
    if (!rst1_n) rd1_sh <= '0;
    else         rd1_sh <= {rd1_sh[SHW-2:0], rd1_tog};

  assign clr1 = rd1_sh[SHW-1] ^ rd1_sh[SHW-2];

  always_ff @(posedge clk_a or negedge rst1_n)
    if (!rst1_n) begin
      full1   <= 1'b0;
      mail1_q <= '0;
    end else if (a_mbx_wr && !full1) begin
      full1   <= 1'b1;
      mail1_q <= a_wdata;
    end else if (clr1) begin
      full1   <= 1'b0;
    end

  assign mail1_full_n = ~full1;

  AST_MAIL1_SET: assert property (@(posedge clk_a) disable iff (!rst1_n) (a_mbx_wr && mail1_full_n) |=> !mail1_full_n); // R3
  AST_MAIL1_HOLD: assert property (@(posedge clk_a) disable iff (!rst1_n) !mail1_full_n |=> $stable(mail1_q)); // R4
  AST_MAIL1_KEEP: assert property (@(posedge clk_a) disable iff (!rst1_n) (!mail1_full_n && !clr1) |=> !mail1_full_n); // R5

  // B-to-A direction
  logic [WIDTH-1:0] mail2_q;
  logic             full2, rd2_tog, clr2;
  logic [SHW-1:0]   rd2_sh;

  always_ff @(posedge clk_a or negedge rst2_n)
    if (!rst2_n)       rd2_tog <= 1'b0;
    else if (a_mbx_rd) rd2_tog <= ~rd2_tog;

  always_ff @(posedge clk_b or negedge rst2_n)
    if (!rst2_n) rd2_sh <= '0;
    else         rd2_sh <= {rd2_sh[SHW-2:0], rd2_tog};

  assign clr2 = rd2_sh[SHW-1] ^ rd2_sh[SHW-2];

  always_ff @(posedge clk_b or negedge rst2_n)
    if (!rst2_n) begin
      full2   <= 1'b0;
      mail2_q <= '0;
    end else if (b_mbx_wr && !full2) begin
      full2   <= 1'b1;
      mail2_q <= b_wdata;
    end else if (clr2) begin
      full2   <= 1'b0;
    end

  assign mail2_full_n = ~full2;

  AST_MAIL2_SET: assert property (@(posedge clk_b) disable iff (!rst2_n) (b_mbx_wr && mail2_full_n) |=> !mail2_full_n); // R6
  AST_MAIL2_HOLD: assert property (@(posedge clk_b) disable iff (!rst2_n) !mail2_full_n |=> $stable(mail2_q)); // R6
  AST_MAIL2_KEEP: assert property (@(posedge clk_b) disable iff (!rst2_n) (!mail2_full_n && !clr2) |=> !mail2_full_n); // R6

  // Read paths
  assign a_rdata = a_mbx_sel ? mail2_q : fifo2_q;
  assign b_rdata = b_mbx_sel ? mail1_q : fifo1_q;
  assign a_oe    = ~a_wr_rd;
  assign b_oe    = b_wr_rd;

endmodule

// File: tb/test_mailbox_pair.sv
`timescale 1ns/100ps
module test_mailbox_pair;
  localparam int  W            = 36;
  localparam real CLK_A_PERIOD = 10.0;
  localparam real CLK_B_PERIOD = 17.0;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst1_n, rst2_n;
  logic a_wr_rd, a_mbx_sel, b_wr_rd, b_mbx_sel;
  logic [W-1:0] a_wdata, b_wdata, fifo1_q, fifo2_q, a_rdata, b_rdata;
  logic a_oe, b_oe, mail1_full_n, mail2_full_n;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] seen;

  mailbox_pair #(.WIDTH(W), .SYNC_STAGES(2)) i_mailbox_pair (
    .clk_a(clk_a), .clk_b(clk_b), .rst1_n(rst1_n), .rst2_n(rst2_n),
    .a_wr_rd(a_wr_rd), .a_mbx_sel(a_mbx_sel), .a_wdata(a_wdata), .fifo2_q(fifo2_q),
    .a_rdata(a_rdata), .a_oe(a_oe), .mail1_full_n(mail1_full_n),
    .b_wr_rd(b_wr_rd), .b_mbx_sel(b_mbx_sel), .b_wdata(b_wdata), .fifo1_q(fifo1_q),
    .b_rdata(b_rdata), .b_oe(b_oe), .mail2_full_n(mail2_full_n));

  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  initial begin
    #0.3;
    forever #(CLK_B_PERIOD/2) clk_b = ~clk_b;
  end

  // row = {a_wr_rd, a_mbx_sel, b_wr_rd, b_mbx_sel}
  localparam logic [3:0] ROWS [5] = '{4'b0111, 4'b0010, 4'b1000, 4'b0100, 4'b1011};

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic a_cyc(input logic wr, input logic sel, input logic [W-1:0] d);
    @(negedge clk_a);
    a_wr_rd = wr; a_mbx_sel = sel; a_wdata = d;
    #1 seen = a_rdata;
    @(negedge clk_a);
    a_wr_rd = 1'b0; a_mbx_sel = 1'b0;
    #1;
  endtask

  task automatic b_cyc(input logic wr, input logic sel, input logic [W-1:0] d);
    @(negedge clk_b);
    b_wr_rd = wr; b_mbx_sel = sel; b_wdata = d;
    #1 seen = b_rdata;
    @(negedge clk_b);
    b_wr_rd = 1'b1; b_mbx_sel = 1'b0;
    #1;
  endtask

  task automatic wait_a(input int n);
    repeat (n) @(negedge clk_a);
    #1;
  endtask

  task automatic wait_b(input int n);
    repeat (n) @(negedge clk_b);
    #1;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_A_PERIOD*20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    rst1_n = 0; rst2_n = 0;
    a_wr_rd = 0; a_mbx_sel = 0; b_wr_rd = 1; b_mbx_sel = 0;
    a_wdata = '0; b_wdata = '0;
    fifo1_q = 36'hF1F1F1F11; fifo2_q = 36'hF2F2F2F22;
    wait_a(20);
    chk(mail1_full_n == 1'b1, "R8 reset mail1 flag", W'(mail1_full_n), W'(1));
    chk(mail2_full_n == 1'b1, "R8 reset mail2 flag", W'(mail2_full_n), W'(1));
    chk(a_oe == 1'b1, "R1 a_oe on read", W'(a_oe), W'(1));
    chk(b_oe == 1'b1, "R2 b_oe on read", W'(b_oe), W'(1));
    @(negedge clk_a); rst1_n = 1; rst2_n = 1;
    wait_a(3);

    // A-to-B direction
    a_cyc(1, 1, 36'h123456789);
    chk(mail1_full_n == 1'b0, "R3 flag low after write", W'(mail1_full_n), W'(0));
    chk(mail2_full_n == 1'b1, "R3 other flag untouched", W'(mail2_full_n), W'(1));
    a_cyc(1, 1, 36'hABCDEF012);
    wait_a(6);
    chk(mail1_full_n == 1'b0, "R5 flag held without read", W'(mail1_full_n), W'(0));
    b_cyc(1, 1, '0);
    chk(seen == 36'h123456789, "R4 overwrite dropped", seen, 36'h123456789);
    wait_a(5);
    chk(mail1_full_n == 1'b1, "R5 flag released after read", W'(mail1_full_n), W'(1));
    a_cyc(1, 1, 36'h0DEADBEEF);
    chk(mail1_full_n == 1'b0, "R3 write after release", W'(mail1_full_n), W'(0));

    // B-to-A direction
    b_cyc(0, 1, 36'h876543210);
    chk(mail2_full_n == 1'b0, "R6 flag low after write", W'(mail2_full_n), W'(0));
    b_cyc(0, 1, 36'h555555555);
    wait_b(6);
    chk(mail2_full_n == 1'b0, "R6 flag held without read", W'(mail2_full_n), W'(0));
    a_cyc(0, 1, '0);
    chk(seen == 36'h876543210, "R6 overwrite dropped", seen, 36'h876543210);
    wait_b(5);
    chk(mail2_full_n == 1'b1, "R6 flag released after read", W'(mail2_full_n), W'(1));

    b_cyc(1, 1, '0);
    chk(seen == 36'h0DEADBEEF, "R3 second word delivered", seen, 36'h0DEADBEEF);
    wait_a(5);
    chk(mail1_full_n == 1'b1, "R5 release again", W'(mail1_full_n), W'(1));

    // FIFO-path writes leave mailboxes alone
    a_cyc(1, 0, 36'hBADBADBAD);
    chk(mail1_full_n == 1'b1, "R9 A fifo write no flag", W'(mail1_full_n), W'(1));
    b_cyc(0, 0, 36'hBADBADBAD);
    chk(mail2_full_n == 1'b1, "R9 B fifo write no flag", W'(mail2_full_n), W'(1));

    // Table of multiplexer / enable vectors
    a_cyc(1, 1, 36'h111122223);
    b_cyc(0, 1, 36'h444455556);
    wait_a(4);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_a);
      {a_wr_rd, a_mbx_sel, b_wr_rd, b_mbx_sel} = ROWS[i];
      a_wdata = 36'hBADBADBAD; b_wdata = 36'hBADBADBAD;
      fifo1_q = 36'h100000000 + W'(i); fifo2_q = 36'h200000000 + W'(i);
      #1;
      chk(a_oe == !ROWS[i][3], "R1 table a_oe", W'(a_oe), W'(!ROWS[i][3]));
      chk(b_oe == ROWS[i][1], "R2 table b_oe", W'(b_oe), W'(ROWS[i][1]));
      chk(a_rdata == (ROWS[i][2] ? 36'h444455556 : fifo2_q), "R7 table a_rdata", a_rdata,
          ROWS[i][2] ? 36'h444455556 : fifo2_q);
      chk(b_rdata == (ROWS[i][0] ? 36'h111122223 : fifo1_q), "R7 table b_rdata", b_rdata,
          ROWS[i][0] ? 36'h111122223 : fifo1_q);
      wait_a(2);
    end
    @(negedge clk_a);
    a_wr_rd = 0; a_mbx_sel = 0; b_wr_rd = 1; b_mbx_sel = 0;
    wait_a(10);

    // Independent resets
    a_cyc(1, 1, 36'h777777777);
    b_cyc(0, 1, 36'h888888888);
    wait_a(2);
    @(negedge clk_a); rst1_n = 0;
    wait_a(10);
    chk(mail1_full_n == 1'b1, "R8 rst1 sets mail1 flag", W'(mail1_full_n), W'(1));
    chk(mail2_full_n == 1'b0, "R8 rst1 spares mail2", W'(mail2_full_n), W'(0));
    @(negedge clk_a); rst1_n = 1;
    wait_a(3);
    b_cyc(1, 1, '0);
    chk(seen == '0, "R8 mail1 cleared", seen, '0);
    @(negedge clk_a); rst2_n = 0;
    wait_a(10);
    chk(mail2_full_n == 1'b1, "R8 rst2 sets mail2 flag", W'(mail2_full_n), W'(1));
    @(negedge clk_a); rst2_n = 1;
    wait_a(3);
    a_cyc(0, 1, '0);
    chk(seen == '0, "R8 mail2 cleared", seen, '0);

    finish_run();
  end
endmodule